// File: doc/BRIEF.md
# Counter-Mode Line Encryption Engine

This block sits between the last-level cache and off-chip memory. It scrambles lines that leave the chip on writeback and unscrambles lines that return on a fill. In both directions it XORs the line with a pad. A keyed mixing pipeline derives that pad from a per-line seed. The seed joins a logical page number, the line's position inside the page and a per-line write count. No address and no process identifier enter the seed. A page can therefore move to another frame, go out to swap and come back, or be mapped by several processes without being re-encrypted.

The requester presents one transaction at a time on the request port. A writeback carries the plaintext line and the line's stored count. The engine bumps the count, builds the pad from the bumped value and returns the ciphertext together with the new count, which the requester stores. A fill carries the same identifiers and the stored count. Pad generation starts at once, while the line is still being fetched. The ciphertext from memory is taken on the memory return port, whether it arrives before or after the pad is ready.

Top module: `ctr_mem_crypt`

## Requirements
- R1: The seed is 128 bits, laid out from the most significant bit down: 58 zero bits, the 32-bit logical page number, the 6-bit line offset, then the 32-bit count in the low bits. A change to page, offset or count alone changes the pad.
- R2: A writeback with count n (n below all-ones) returns count n+1 on `ctr_o` and encrypts with the pad of n+1. A fill that presents count n+1 therefore uses that same pad.
- R3: A writeback whose count is all-ones sets `ovf_o`, returns all-ones on `ctr_o` and does not wrap. `ovf_o` is 0 on every other result.
- R4: A fill outputs the memory data XOR the pad, so a fill of a writeback's ciphertext with the returned count gives back the original plaintext.
- R5: Both directions are a pure bitwise XOR with the pad. For one seed, the XOR of two ciphertexts equals the XOR of their plaintexts.
- R6: A request is taken on a rising edge while `busy_o` is 0; call that edge 0. When fill data is taken no later than edge 4, and for every writeback, `out_valid_o` pulses for one cycle right after edge 4.
- R7: Fill data that arrives early is held until the pad is ready. Fill data taken on edge k, with k at least 4, produces the output right after edge k.
- R8: `busy_o` is 1 from the accepting edge until the result edge. Requests presented while busy are ignored and leave the pending result unchanged.
- R9: After reset, `out_valid_o` and `busy_o` are 0.
- R10: The pad depends on the key: the same writeback under a different key gives a different ciphertext, and the round trip of R4 still holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| key_i | input | 128 | Mixing key |
| req_valid_i | input | 1 | Request strobe |
| req_wb_i | input | 1 | 1 = writeback, 0 = fill |
| req_page_i | input | 32 | Logical page number |
| req_off_i | input | 6 | Line offset within page |
| req_ctr_i | input | 32 | Stored line count |
| req_data_i | input | 128 | Plaintext line (writeback) |
| mem_valid_i | input | 1 | Fill data strobe from memory |
| mem_data_i | input | 128 | Ciphertext line from memory |
| busy_o | output | 1 | Transaction in flight |
| out_valid_o | output | 1 | Result pulse |
| out_wb_o | output | 1 | Result belongs to a writeback |
| out_data_o | output | 128 | Ciphertext (writeback) or plaintext (fill) |
| ctr_o | output | 32 | Count to store (bumped on writeback) |
| ovf_o | output | 1 | Writeback count saturated |

## Verification
The bench uses the all-ones count. An engine that wraps the count would return zero there and clear the overflow flag. It runs fills whose data arrives early, exactly on edge 4, and late. Dropping the one-entry hold would lose early data, and a bad pad handshake would move the result pulse. Each writeback is replayed as a fill with the returned count. Building the pad from the old count would break this round trip, while an XOR-linearity pair and a zero-data comparison pin the pad to the bumped value. A second request sent while busy shows that an engine which re-accepts would corrupt the pending result.

// File: rtl/cme_pkg.sv
package cme_pkg;
  localparam int LINE_W = 128;
  localparam int PAGE_W = 32;
  localparam int OFF_W  = 6;
  localparam int CTR_W  = 32;
  localparam int ROUNDS = 4;
  localparam int HALF_W = LINE_W / 2;

  // one keyed ARX round over two halves
  function automatic logic [LINE_W-1:0] mix_round(input logic [LINE_W-1:0] x,
                                                  input logic [LINE_W-1:0] k,
                                                  input int unsigned r);
    logic [LINE_W-1:0] y;
    logic [HALF_W-1:0] a, b;
    y = x ^ k ^ {(LINE_W/32){32'h9E37_79B9 ^ 32'(r)}};
    a = y[LINE_W-1:HALF_W];
    b = y[HALF_W-1:0];
    a = a + b;
    b = ((b << 17) | (b >> (HALF_W-17))) ^ a;
    a = ((a << 25) | (a >> (HALF_W-25))) + b;
    return {b, a};
  endfunction
endpackage

// File: rtl/cme_seed.sv
module cme_seed #(
  parameter int LINE_W = cme_pkg::LINE_W,
  parameter int PAGE_W = cme_pkg::PAGE_W,
  parameter int OFF_W  = cme_pkg::OFF_W,
  parameter int CTR_W  = cme_pkg::CTR_W
) (
  input  logic [PAGE_W-1:0] page_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [CTR_W-1:0]  ctr_i,
  input  logic              wb_i,
  output logic [LINE_W-1:0] seed_o,
  output logic [CTR_W-1:0]  ctr_o,
  output logic              sat_o
);
  localparam int PAD_W = LINE_W - PAGE_W - OFF_W - CTR_W;

  assign sat_o  = wb_i & (&ctr_i);
  assign ctr_o  = (wb_i && !sat_o) ? ctr_i + CTR_W'(1) : ctr_i;
  assign seed_o = {{PAD_W{1'b0}}, page_i, off_i, ctr_o};
endmodule

// File: rtl/cme_pad_pipe.sv
module cme_pad_pipe #(
  parameter int LINE_W = cme_pkg::LINE_W,
  parameter int STAGES = cme_pkg::ROUNDS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [LINE_W-1:0] seed_i,
  input  logic [LINE_W-1:0] key_i,
  input  logic              take_i,
  output logic              pad_vld_o,
  output logic [LINE_W-1:0] pad_o
);
  logic [STAGES-1:0] vld_vec;

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    logic              v;
    logic [LINE_W-1:0] q;
    logic              src_v;
    logic [LINE_W-1:0] src;
    if (s == 0) begin : g_head
      assign src_v = start_i;
      assign src   = seed_i;
    end else begin : g_body
      assign src_v = g_stg[s-1].v;
      assign src   = g_stg[s-1].q;
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        v <= 1'b0;
        q <= '0;
      end else if (src_v) begin
        v <= 1'b1;
        q <= cme_pkg::mix_round(src, key_i, s);
      end else if ((s == STAGES-1) ? take_i : 1'b1) begin
        v <= 1'b0;  // last stage holds until consumed
      end
    end
    assign vld_vec[s] = v;
  end

  assign pad_vld_o = g_stg[STAGES-1].v;
  assign pad_o     = g_stg[STAGES-1].q;

  p_one_stage_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(vld_vec));
  p_pad_holds_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pad_vld_o && !take_i |=> pad_vld_o && $stable(pad_o));
endmodule

// File: rtl/ctr_mem_crypt.sv
module ctr_mem_crypt #(
  parameter int LINE_W = cme_pkg::LINE_W,
  parameter int PAGE_W = cme_pkg::PAGE_W,
  parameter int OFF_W  = cme_pkg::OFF_W,
  parameter int CTR_W  = cme_pkg::CTR_W,
  parameter int ROUNDS = cme_pkg::ROUNDS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LINE_W-1:0] key_i,
  input  logic              req_valid_i,
  input  logic              req_wb_i,
  input  logic [PAGE_W-1:0] req_page_i,
  input  logic [OFF_W-1:0]  req_off_i,
  input  logic [CTR_W-1:0]  req_ctr_i,
  input  logic [LINE_W-1:0] req_data_i,
  input  logic              mem_valid_i,
  input  logic [LINE_W-1:0] mem_data_i,
  output logic              busy_o,
  output logic              out_valid_o,
  output logic              out_wb_o,
  output logic [LINE_W-1:0] out_data_o,
  output logic [CTR_W-1:0]  ctr_o,
  output logic              ovf_o
);
  logic              accept;
  logic [LINE_W-1:0] seed;
  logic [CTR_W-1:0]  ctr_nxt;
  logic              sat;
  logic              pad_vld;
  logic [LINE_W-1:0] pad;
  logic              take;
  logic              fill_rdy;
  logic [LINE_W-1:0] fill_dat;

  logic              busy_q, wb_q, ovf_q, buf_vld;
  logic [CTR_W-1:0]  ctr_q;
  logic [LINE_W-1:0] wdat_q, buf_q;

  assign accept = req_valid_i & ~busy_q;

  cme_seed #(.LINE_W(LINE_W), .PAGE_W(PAGE_W), .OFF_W(OFF_W), .CTR_W(CTR_W)) u_seed (
    .page_i(req_page_i), .off_i(req_off_i), .ctr_i(req_ctr_i), .wb_i(req_wb_i),
    .seed_o(seed), .ctr_o(ctr_nxt), .sat_o(sat)
  );

  cme_pad_pipe #(.LINE_W(LINE_W), .STAGES(ROUNDS)) u_pad (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(accept), .seed_i(seed), .key_i(key_i),
    .take_i(take), .pad_vld_o(pad_vld), .pad_o(pad)
  );

  // fill data: held copy first, else the live return
  assign fill_rdy = buf_vld | (mem_valid_i & busy_q & ~wb_q);
  assign fill_dat = buf_vld ? buf_q : mem_data_i;
  assign take     = pad_vld & (wb_q | fill_rdy);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q      <= 1'b0;
      wb_q        <= 1'b0;
      ovf_q       <= 1'b0;
      ctr_q       <= '0;
      wdat_q      <= '0;
      buf_vld     <= 1'b0;
      buf_q       <= '0;
      out_valid_o <= 1'b0;
      out_wb_o    <= 1'b0;
      out_data_o  <= '0;
      ctr_o       <= '0;
      ovf_o       <= 1'b0;
    end else begin
      out_valid_o <= 1'b0;
      if (accept) begin
        busy_q <= 1'b1;
        wb_q   <= req_wb_i;
        ovf_q  <= sat;
        ctr_q  <= ctr_nxt;
        wdat_q <= req_data_i;
      end
      if (take) begin
        busy_q      <= 1'b0;
        buf_vld     <= 1'b0;
        out_valid_o <= 1'b1;
        out_wb_o    <= wb_q;
        out_data_o  <= pad ^ (wb_q ? wdat_q : fill_dat);
        ctr_o       <= ctr_q;
        ovf_o       <= ovf_q;
      end else if (busy_q && !wb_q && mem_valid_i && !buf_vld) begin
        buf_vld <= 1'b1;
        buf_q   <= mem_data_i;
      end
    end
  end

  assign busy_o = busy_q;

  p_out_after_pad_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> $past(pad_vld) && $past(busy_q));
  p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && ovf_o |-> out_wb_o && (&ctr_o));
  p_idle_after_out_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> !busy_o);
  p_buf_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_vld && !pad_vld |=> buf_vld && $stable(buf_q));
endmodule

// File: tb/tb_ctr_mem_crypt.sv
`timescale 1ns/1ps
module tb_ctr_mem_crypt;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [127:0] key = 128'h0F1E2D3C_4B5A6978_8796A5B4_C3D2E1F0;
  logic         req_valid = 1'b0, req_wb = 1'b0;
  logic [31:0]  req_page = '0, req_ctr = '0;
  logic [5:0]   req_off = '0;
  logic [127:0] req_data = '0;
  logic         mem_valid = 1'b0;
  logic [127:0] mem_data = '0;
  logic         busy, out_valid, out_wb, ovf;
  logic [127:0] out_data;
  logic [31:0]  ctr_out;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ctr_mem_crypt dut (
    .clk_i(clk), .rst_ni(rst_n), .key_i(key), .req_valid_i(req_valid), .req_wb_i(req_wb),
    .req_page_i(req_page), .req_off_i(req_off), .req_ctr_i(req_ctr), .req_data_i(req_data),
    .mem_valid_i(mem_valid), .mem_data_i(mem_data), .busy_o(busy), .out_valid_o(out_valid),
    .out_wb_o(out_wb), .out_data_o(out_data), .ctr_o(ctr_out), .ovf_o(ovf)
  );

  // {page, offset, count, plaintext}
  localparam logic [197:0] VEC [6] = '{
    {32'h0000_0001, 6'd0,  32'h0000_0000, 128'h0011_2233_4455_6677_8899_AABB_CCDD_EEFF},
    {32'h0000_0001, 6'd63, 32'h0000_0007, 128'hFFFF_FFFF_0000_0000_FFFF_FFFF_0000_0000},
    {32'hDEAD_BEEF, 6'd17, 32'h1234_5678, 128'h0},
    {32'h8000_0000, 6'd1,  32'hFFFF_FFFE, 128'hA5A5_A5A5_5A5A_5A5A_A5A5_A5A5_5A5A_5A5A},
    {32'hFFFF_FFFF, 6'd42, 32'h0000_FFFF, 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210},
    {32'h0000_0000, 6'd5,  32'h7FFF_FFFF, 128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF}
  };

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  // one transaction; md = negedges after accept before fill data; extra = stray request while busy
  task automatic txn(input bit wb, input logic [31:0] pg, input logic [5:0] of,
                     input logic [31:0] ct, input logic [127:0] d, input int md, input bit extra,
                     output logic [127:0] od, output logic [31:0] oc, output bit ov, output int lat);
    @(negedge clk);
    req_valid = 1'b1; req_wb = wb; req_page = pg; req_off = of; req_ctr = ct; req_data = d;
    mem_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = -1; od = '0; oc = '0; ov = 1'b0;
    for (int n = 0; n < 40; n++) begin
      if (extra && n == 0) begin
        chk(busy == 1'b1, "R8", "busy after accept", 128'(busy), 128'd1);
        req_valid = 1'b1; req_wb = 1'b1; req_page = pg ^ 32'h55; req_ctr = ct + 32'd9;
        req_data = ~d;
      end else begin
        req_valid = 1'b0;
      end
      if (!wb && n == md) begin mem_valid = 1'b1; mem_data = d; end
      else mem_valid = 1'b0;
      @(posedge clk);
      @(negedge clk);
      if (out_valid) begin
        lat = n + 1; od = out_data; oc = ctr_out; ov = ovf;
        break;
      end
    end
    req_valid = 1'b0;
    mem_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [127:0] c, c2, p, z0, z1;
    logic [31:0]  oc;
    bit           ov;
    int           lat;

    // R9 reset state
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R9", "out_valid in reset", 128'(out_valid), 128'd0);
    chk(busy == 1'b0, "R9", "busy in reset", 128'(busy), 128'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0 && busy == 1'b0, "R9", "idle after reset", 128'({out_valid, busy}), 128'd0);

    // table: writeback then fill replay (R2, R4, R6)
    for (int i = 0; i < 6; i++) begin
      logic [31:0]  pg, ct;
      logic [5:0]   of;
      logic [127:0] pt;
      {pg, of, ct, pt} = VEC[i];
      txn(1'b1, pg, of, ct, pt, 0, 1'b0, c, oc, ov, lat);
      chk(lat == 4, "R6", "writeback latency", 128'(lat), 128'd4);
      chk(oc == ct + 32'd1, "R2", "bumped count", 128'(oc), 128'(ct + 32'd1));
      chk(ov == 1'b0, "R3", "no overflow below max", 128'(ov), 128'd0);
      chk(c != pt, "R4", "ciphertext differs", c, pt);
      txn(1'b0, pg, of, ct + 32'd1, c, i % 3, 1'b0, p, oc, ov, lat);
      chk(p == pt, "R4", "round trip", p, pt);
      chk(oc == ct + 32'd1, "R2", "fill count unchanged", 128'(oc), 128'(ct + 32'd1));
      chk(lat == 4, "R6", "early fill latency", 128'(lat), 128'd4);
    end

    // R2: pad of writeback(count n, zero data) equals pad seen by fill(count n+1, zero data)
    txn(1'b1, 32'h0000_0AB0, 6'd3, 32'd10, 128'h0, 0, 1'b0, z0, oc, ov, lat);
    txn(1'b0, 32'h0000_0AB0, 6'd3, 32'd11, 128'h0, 1, 1'b0, z1, oc, ov, lat);
    chk(z0 == z1, "R2", "writeback pad uses bumped count", z0, z1);

    // R1: each seed field alone moves the pad
    txn(1'b0, 32'h0000_0AB1, 6'd3, 32'd11, 128'h0, 0, 1'b0, c, oc, ov, lat);
    chk(c != z1, "R1", "page changes pad", c, z1);
    txn(1'b0, 32'h0000_0AB0, 6'd2, 32'd11, 128'h0, 0, 1'b0, c, oc, ov, lat);
    chk(c != z1, "R1", "offset changes pad", c, z1);
    txn(1'b0, 32'h0000_0AB0, 6'd3, 32'd12, 128'h0, 0, 1'b0, c, oc, ov, lat);
    chk(c != z1, "R1", "count changes pad", c, z1);

    // R5: XOR linearity under one seed
    txn(1'b1, 32'h0000_0777, 6'd9, 32'd3, 128'h1234, 0, 1'b0, c, oc, ov, lat);
    txn(1'b1, 32'h0000_0777, 6'd9, 32'd3, 128'hF0F0_0000_0000_0000_0000_0000_0000_1111,
        0, 1'b0, c2, oc, ov, lat);
    chk((c ^ c2) == (128'h1234 ^ 128'hF0F0_0000_0000_0000_0000_0000_0000_1111), "R5",
        "ciphertext xor", c ^ c2, 128'h1234 ^ 128'hF0F0_0000_0000_0000_0000_0000_0000_1111);

    // R7: fill data exactly at edge 4 and late
    txn(1'b0, 32'h0000_0AB0, 6'd3, 32'd11, 128'h0, 3, 1'b0, c, oc, ov, lat);
    chk(lat == 4, "R7", "fill at edge 4", 128'(lat), 128'd4);
    chk(c == z1, "R7", "fill at edge 4 data", c, z1);
    txn(1'b0, 32'h0000_0AB0, 6'd3, 32'd11, 128'h0, 6, 1'b0, c, oc, ov, lat);
    chk(lat == 7, "R7", "late fill latency", 128'(lat), 128'd7);
    chk(c == z1, "R7", "late fill data", c, z1);

    // R3: saturated count
    txn(1'b1, 32'h0000_0042, 6'd0, 32'hFFFF_FFFF, 128'h5, 0, 1'b0, c, oc, ov, lat);
    chk(oc == 32'hFFFF_FFFF, "R3", "count stays all-ones", 128'(oc), 128'hFFFF_FFFF);
    chk(ov == 1'b1, "R3", "overflow flag", 128'(ov), 128'd1);

    // R8: stray request while busy is ignored
    txn(1'b1, 32'h0000_0AB0, 6'd3, 32'd10, 128'h0, 0, 1'b1, c, oc, ov, lat);
    chk(c == z0, "R8", "pending result intact", c, z0);
    chk(oc == 32'd11, "R8", "pending count intact", 128'(oc), 128'd11);
    @(negedge clk);
    @(negedge clk);
    chk(out_valid == 1'b0 && busy == 1'b0, "R8", "stray request not taken",
        128'({out_valid, busy}), 128'd0);

    // R10: key dependence
    key = 128'h1;
    txn(1'b1, 32'h0000_0AB0, 6'd3, 32'd10, 128'h0, 0, 1'b0, c, oc, ov, lat);
    chk(c != z0, "R10", "key changes pad", c, z0);
    txn(1'b1, 32'h0000_0AB0, 6'd3, 32'd10, 128'hCAFE, 0, 1'b0, c, oc, ov, lat);
    txn(1'b0, 32'h0000_0AB0, 6'd3, 32'd11, c, 2, 1'b0, p, oc, ov, lat);
    chk(p == 128'hCAFE, "R10", "round trip under new key", p, 128'hCAFE);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule